// File: doc/BRIEF.md
# Exception Entry Controller

This block sits between a core's exception sources and its status and fetch logic. Eight request lines are presented as levels: reset, data abort, fast interrupt, normal interrupt, imprecise abort, prefetch abort, undefined instruction and software interrupt. A fixed priority picks the winner after the interrupt masks in the current status word have been applied. On the next clock edge the block registers everything the core needs to enter that exception:

- the new processor mode;
- the rewritten status word;
- the status word to save as the old status;
- the link address;
- the address of the handler to fetch.

It pulses a one-cycle entry strobe alongside these outputs.

The core supplies the current status word, the address used for link generation, a high-vector select, the endianness value to load on entry, an enable for externally supplied interrupt vectors, and that external vector. While the strobe is high, the block does not arbitrate. Requests still asserted during that cycle are considered on the following edge, so two entries are always at least one idle cycle apart. The registered outputs keep their last values between strobes.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The block samples the requests on a rising edge where `entry_o` is low. If any request is accepted, `entry_o` is high for exactly the following cycle, and the other outputs are valid in that same cycle. Requests present while `entry_o` is high are not taken on that edge; they are arbitrated on the next edge. `entry_o` is therefore never high in two consecutive cycles.
- R2: The vector address is a base plus an offset.
  - The base is `HI_BASE` (default 0xFFFF0000) when `hivec_i` is 1, and 0 otherwise.
  - The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, imprecise abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R3: On every entry, the new status word is formed as follows:
  - bits [4:0] hold the new mode;
  - bit 5 is cleared;
  - bit 7 is set;
  - bit 9 takes `ee_i`;
  - bits above 9 are copied from `stat_i`.
- R4: Status bit 6 is set on reset and fast-interrupt entry and is copied from `stat_i` otherwise. Status bit 8 is set on reset, fast interrupt, normal interrupt and all three aborts, and is copied from `stat_i` on undefined and software-interrupt entry.
- R5: A normal interrupt is taken only when `stat_i[7]` is 0, and a fast interrupt only when `stat_i[6]` is 0. A masked request on its own produces no entry.
- R6: The priority from highest to lowest is reset, data abort, fast interrupt, normal interrupt, imprecise abort, prefetch abort, then undefined instruction and software interrupt. The request input bit order in the bench is [0] reset up to [7] software interrupt, in this same order.
- R7: The mode encodings are:
  - supervisor 5'b10011, used for both reset and software interrupt;
  - undefined 5'b11011;
  - normal interrupt 5'b10010;
  - fast interrupt 5'b10001;
  - abort 5'b10111, used for all three aborts.
- R8: The link address depends on the winning class:
  - `pc_i`+8 for a data abort;
  - 0 for reset;
  - `pc_i`+4 for every other class.

  The saved status equals `stat_i`, except on reset entry, where it is 0.
- R9: If undefined instruction and software interrupt are requested together and one of them wins, undefined instruction is taken and `clash_o` is high with that strobe. Otherwise `clash_o` is low.
- R10: When `vec_ext_en_i` is 1, normal and fast interrupt entries take `vec_ext_i` as the vector. Every other class still uses the table address.
- R11: While `rst_ni` is low, `entry_o`, `clash_o` and all data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the block's registers |
| req_rst_i | input | 1 | Reset exception request |
| req_dabt_i | input | 1 | Data abort request |
| req_fiq_i | input | 1 | Fast interrupt request |
| req_irq_i | input | 1 | Normal interrupt request |
| req_iabt_i | input | 1 | Imprecise abort request |
| req_pabt_i | input | 1 | Prefetch abort request |
| req_und_i | input | 1 | Undefined instruction request |
| req_swi_i | input | 1 | Software interrupt request |
| stat_i | input | STAT_W | Current status word |
| pc_i | input | ADDR_W | Address the link value is derived from |
| hivec_i | input | 1 | Selects the high vector base |
| ee_i | input | 1 | Endianness bit loaded on entry |
| vec_ext_en_i | input | 1 | Use external vector for interrupt entries |
| vec_ext_i | input | ADDR_W | External interrupt vector |
| entry_o | output | 1 | One-cycle entry strobe |
| mode_o | output | 5 | New mode field |
| stat_new_o | output | STAT_W | Rewritten status word |
| stat_save_o | output | STAT_W | Status word to save |
| link_o | output | ADDR_W | Link address |
| vec_o | output | ADDR_W | Handler fetch address |
| clash_o | output | 1 | Undefined and software interrupt requested together |

## Verification
The bench builds the block with `ADDR_W`=32, `STAT_W`=12 and `EXT_VEC`=1. The 12-bit status word keeps bits 10 and 11 in play, so the copy of the upper status bits through every entry class can be observed. The external vector path is present in this build, so its selection for interrupt classes, and its absence for the others, is observable at `vec_o`. The full 32-bit address width lets the high base 0xFFFF0000 and both link offsets appear on the ports unchanged.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

   localparam int NCLS = 8;

   // index order is the priority order, index 0 highest
   typedef enum logic [2:0] {
      CLS_RST  = 3'd0,
      CLS_DABT = 3'd1,
      CLS_FIQ  = 3'd2,
      CLS_IRQ  = 3'd3,
      CLS_IABT = 3'd4,
      CLS_PABT = 3'd5,
      CLS_UND  = 3'd6,
      CLS_SWI  = 3'd7
   } exc_cls_e;

   localparam logic [4:0] MODE_SVC = 5'b10011;
   localparam logic [4:0] MODE_UND = 5'b11011;
   localparam logic [4:0] MODE_IRQ = 5'b10010;
   localparam logic [4:0] MODE_FIQ = 5'b10001;
   localparam logic [4:0] MODE_ABT = 5'b10111;

   localparam int SB_T = 5;
   localparam int SB_F = 6;
   localparam int SB_I = 7;
   localparam int SB_A = 8;
   localparam int SB_E = 9;

   function automatic logic [4:0] cls_mode(int i);
      case (i)
         0, 7:    return MODE_SVC;
         2:       return MODE_FIQ;
         3:       return MODE_IRQ;
         6:       return MODE_UND;
         default: return MODE_ABT;
      endcase
   endfunction

   function automatic logic [7:0] cls_voff(int i);
      case (i)
         0:       return 8'h00;
         1, 4:    return 8'h10;
         2:       return 8'h1C;
         3:       return 8'h18;
         5:       return 8'h0C;
         6:       return 8'h04;
         default: return 8'h08;
      endcase
   endfunction

   function automatic logic [3:0] cls_ladd(int i);
      case (i)
         0:       return 4'd0;
         1:       return 4'd8;
         default: return 4'd4;
      endcase
   endfunction

   function automatic logic cls_set_f(int i);
      return (i == 0) || (i == 2);
   endfunction

   function automatic logic cls_set_a(int i);
      return (i <= 5);
   endfunction

endpackage

// File: rtl/exc_entry_arb.sv
module exc_entry_arb
   import exc_entry_pkg::*;
(
   input  logic [NCLS-1:0] req_i,
   input  logic            mask_f_i,
   input  logic            mask_i_i,
   output logic [NCLS-1:0] grant_o,
   output logic            any_o,
   output logic            clash_o
);

   logic [NCLS-1:0] eff;

   always_comb begin
      eff          = req_i;
      eff[CLS_FIQ] = req_i[CLS_FIQ] & ~mask_f_i;
      eff[CLS_IRQ] = req_i[CLS_IRQ] & ~mask_i_i;
   end

   for (genvar i = 0; i < NCLS; i++) begin : g_pri
      if (i == 0) begin : g_top
         assign grant_o[i] = eff[i];
      end else begin : g_rest
         assign grant_o[i] = eff[i] & ~|eff[i-1:0];
      end
   end

   assign any_o   = |eff;
   assign clash_o = grant_o[CLS_UND] & eff[CLS_SWI];

endmodule

// File: rtl/exc_entry_stat.sv
module exc_entry_stat
   import exc_entry_pkg::*;
#(
   parameter int STAT_W = 32
) (
   input  logic [NCLS-1:0]   grant_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic              ee_i,
   output logic [4:0]        mode_o,
   output logic [STAT_W-1:0] stat_new_o,
   output logic [STAT_W-1:0] stat_save_o
);

   logic set_f;
   logic set_a;

   always_comb begin
      mode_o = '0;
      set_f  = 1'b0;
      set_a  = 1'b0;
      for (int i = 0; i < NCLS; i++) begin
         if (grant_i[i]) begin
            mode_o = mode_o | cls_mode(i);
            set_f  = set_f  | cls_set_f(i);
            set_a  = set_a  | cls_set_a(i);
         end
      end
   end

   always_comb begin
      stat_new_o        = stat_i;
      stat_new_o[4:0]   = mode_o;
      stat_new_o[SB_T]  = 1'b0;
      stat_new_o[SB_I]  = 1'b1;
      stat_new_o[SB_E]  = ee_i;
      if (set_f) stat_new_o[SB_F] = 1'b1;
      if (set_a) stat_new_o[SB_A] = 1'b1;
   end

   assign stat_save_o = grant_i[CLS_RST] ? '0 : stat_i;

endmodule

// File: rtl/exc_entry_addr.sv
module exc_entry_addr
   import exc_entry_pkg::*;
#(
   parameter int              ADDR_W  = 32,
   parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000,
   parameter bit              EXT_VEC = 1'b1
) (
   input  logic [NCLS-1:0]   grant_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              hivec_i,
   input  logic              vx_en_i,
   input  logic [ADDR_W-1:0] vx_i,
   output logic [ADDR_W-1:0] link_o,
   output logic [ADDR_W-1:0] vec_o
);

   localparam int PAD_W = ADDR_W - 8;

   logic [7:0]        off;
   logic [3:0]        ladd;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] tbl_vec;
   logic              use_ext;

   always_comb begin
      off  = '0;
      ladd = '0;
      for (int i = 0; i < NCLS; i++) begin
         if (grant_i[i]) begin
            off  = off  | cls_voff(i);
            ladd = ladd | cls_ladd(i);
         end
      end
   end

   assign link_o  = grant_i[CLS_RST] ? '0 : pc_i + ADDR_W'(ladd);
   assign base    = hivec_i ? HI_BASE : '0;
   assign tbl_vec = base | {{PAD_W{1'b0}}, off};

   if (EXT_VEC) begin : g_ext
      assign use_ext = vx_en_i & (grant_i[CLS_IRQ] | grant_i[CLS_FIQ]);
   end else begin : g_tbl
      assign use_ext = vx_en_i & 1'b0;
   end

   assign vec_o = use_ext ? vx_i : tbl_vec;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int                ADDR_W  = 32,
   parameter int                STAT_W  = 32,
   parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000,
   parameter bit                EXT_VEC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_rst_i,
   input  logic              req_dabt_i,
   input  logic              req_fiq_i,
   input  logic              req_irq_i,
   input  logic              req_iabt_i,
   input  logic              req_pabt_i,
   input  logic              req_und_i,
   input  logic              req_swi_i,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              hivec_i,
   input  logic              ee_i,
   input  logic              vec_ext_en_i,
   input  logic [ADDR_W-1:0] vec_ext_i,
   output logic              entry_o,
   output logic [4:0]        mode_o,
   output logic [STAT_W-1:0] stat_new_o,
   output logic [STAT_W-1:0] stat_save_o,
   output logic [ADDR_W-1:0] link_o,
   output logic [ADDR_W-1:0] vec_o,
   output logic              clash_o
);

   if (STAT_W < 10) begin : g_bad_stat
      $error("STAT_W must hold status bits up to 9");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the vector offsets");
   end
   if (HI_BASE[7:0] != 8'h00) begin : g_bad_base
      $error("HI_BASE low byte must be zero");
   end

   logic [NCLS-1:0]   req;
   logic [NCLS-1:0]   grant;
   logic              any_req;
   logic              clash_c;
   logic [4:0]        mode_c;
   logic [STAT_W-1:0] snew_c;
   logic [STAT_W-1:0] ssave_c;
   logic [ADDR_W-1:0] link_c;
   logic [ADDR_W-1:0] vec_c;
   logic              take;

   assign req = {req_swi_i, req_und_i, req_pabt_i, req_iabt_i,
                 req_irq_i, req_fiq_i, req_dabt_i, req_rst_i};

   exc_entry_arb u_arb (
      .req_i    (req),
      .mask_f_i (stat_i[SB_F]),
      .mask_i_i (stat_i[SB_I]),
      .grant_o  (grant),
      .any_o    (any_req),
      .clash_o  (clash_c)
   );

   exc_entry_stat #(.STAT_W(STAT_W)) u_stat (
      .grant_i     (grant),
      .stat_i      (stat_i),
      .ee_i        (ee_i),
      .mode_o      (mode_c),
      .stat_new_o  (snew_c),
      .stat_save_o (ssave_c)
   );

   exc_entry_addr #(.ADDR_W(ADDR_W), .HI_BASE(HI_BASE), .EXT_VEC(EXT_VEC)) u_addr (
      .grant_i (grant),
      .pc_i    (pc_i),
      .hivec_i (hivec_i),
      .vx_en_i (vec_ext_en_i),
      .vx_i    (vec_ext_i),
      .link_o  (link_c),
      .vec_o   (vec_c)
   );

   // no arbitration during the strobe cycle
   assign take = any_req & ~entry_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         entry_o     <= 1'b0;
         mode_o      <= '0;
         stat_new_o  <= '0;
         stat_save_o <= '0;
         link_o      <= '0;
         vec_o       <= '0;
         clash_o     <= 1'b0;
      end else begin
         entry_o <= take;
         clash_o <= take & clash_c;
         if (take) begin
            mode_o      <= mode_c;
            stat_new_o  <= snew_c;
            stat_save_o <= ssave_c;
            link_o      <= link_c;
            vec_o       <= vec_c;
         end
      end
   end

   AST_ONE_WIN:   assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(grant)); // R6
   AST_STB_GAP:   assert property (@(posedge clk_i) disable iff (!rst_ni) entry_o |=> !entry_o); // R1
   AST_ST_COMMON: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     entry_o |-> (!stat_new_o[SB_T] && stat_new_o[SB_I] && stat_new_o[4:0] == mode_o)); // R3
   AST_EE_LOAD:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     entry_o |-> stat_new_o[SB_E] == $past(ee_i)); // R3
   AST_IRQ_MASK:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (entry_o && mode_o == MODE_IRQ) |-> !$past(stat_i[SB_I])); // R5
   AST_FIQ_MASK:  assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (entry_o && mode_o == MODE_FIQ) |-> (!$past(stat_i[SB_F]) && stat_new_o[SB_F] && stat_new_o[SB_A])); // R4
   AST_VEC_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (entry_o && !$past(vec_ext_en_i)) |-> vec_o[1:0] == 2'b00); // R2
   AST_RST_WIN:   assert property (@(posedge clk_i) disable iff (!rst_ni)
                     (req_rst_i && !entry_o) |=> (entry_o && mode_o == MODE_SVC && vec_o[7:0] == 8'h00)); // R6
   AST_CLASH:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                     clash_o |-> (entry_o && mode_o == MODE_UND)); // R9

endmodule

// File: tb/exc_entry_ctrl_tb.sv
`timescale 1ns/1ps
module exc_entry_ctrl_tb;

   localparam int AW = 32;
   localparam int SW = 12;
   localparam logic [AW-1:0] PC  = 32'h0000_1000;
   localparam logic [AW-1:0] VXT = 32'h0000_8A40;

   typedef struct packed {
      logic [7:0]    req;
      logic [SW-1:0] stat;
      logic          hv;
      logic          ee;
      logic          vx;
      logic [4:0]    mode;
      logic [SW-1:0] snew;
      logic [SW-1:0] ssave;
      logic [AW-1:0] vec;
      logic [AW-1:0] link;
      logic          clash;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t TBL [NV] = '{
      '{8'h80, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h13, 12'hC93, 12'hC10, 32'h0000_0008, 32'h1004, 1'b0}, // swi
      '{8'h40, 12'hD50, 1'b1, 1'b1, 1'b0, 5'h1B, 12'hFDB, 12'hD50, 32'hFFFF_0004, 32'h1004, 1'b0}, // und hi
      '{8'h08, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h12, 12'hD92, 12'hC10, 32'h0000_0018, 32'h1004, 1'b0}, // irq
      '{8'h04, 12'hC10, 1'b1, 1'b0, 1'b0, 5'h11, 12'hDD1, 12'hC10, 32'hFFFF_001C, 32'h1004, 1'b0}, // fiq hi
      '{8'h20, 12'hC30, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC30, 32'h0000_000C, 32'h1004, 1'b0}, // pabt
      '{8'h02, 12'hC10, 1'b1, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC10, 32'hFFFF_0010, 32'h1008, 1'b0}, // dabt hi
      '{8'h10, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC10, 32'h0000_0010, 32'h1004, 1'b0}, // iabt
      '{8'h01, 12'hC10, 1'b0, 1'b1, 1'b0, 5'h13, 12'hFD3, 12'h000, 32'h0000_0000, 32'h0000, 1'b0}, // reset
      '{8'hFF, 12'h010, 1'b0, 1'b0, 1'b0, 5'h13, 12'h1D3, 12'h000, 32'h0000_0000, 32'h0000, 1'b0}, // all
      '{8'h2E, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC10, 32'h0000_0010, 32'h1008, 1'b0}, // dabt wins
      '{8'h1C, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h11, 12'hDD1, 12'hC10, 32'h0000_001C, 32'h1004, 1'b0}, // fiq wins
      '{8'h78, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h12, 12'hD92, 12'hC10, 32'h0000_0018, 32'h1004, 1'b0}, // irq wins
      '{8'hB0, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC10, 32'h0000_0010, 32'h1004, 1'b0}, // iabt wins
      '{8'h60, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC10, 32'h0000_000C, 32'h1004, 1'b0}, // pabt wins
      '{8'h28, 12'hC90, 1'b0, 1'b0, 1'b0, 5'h17, 12'hD97, 12'hC90, 32'h0000_000C, 32'h1004, 1'b0}, // irq masked
      '{8'h44, 12'hC50, 1'b0, 1'b0, 1'b0, 5'h1B, 12'hCDB, 12'hC50, 32'h0000_0004, 32'h1004, 1'b0}, // fiq masked
      '{8'h08, 12'hC10, 1'b0, 1'b0, 1'b1, 5'h12, 12'hD92, 12'hC10, 32'h0000_8A40, 32'h1004, 1'b0}, // irq ext
      '{8'h80, 12'hC10, 1'b1, 1'b0, 1'b1, 5'h13, 12'hC93, 12'hC10, 32'hFFFF_0008, 32'h1004, 1'b0}, // swi ext ignored
      '{8'hC0, 12'hC10, 1'b0, 1'b0, 1'b0, 5'h1B, 12'hC9B, 12'hC10, 32'h0000_0004, 32'h1004, 1'b1}, // clash
      '{8'h04, 12'hC10, 1'b0, 1'b0, 1'b1, 5'h11, 12'hDD1, 12'hC10, 32'h0000_8A40, 32'h1004, 1'b0}  // fiq ext
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    req = '0;
   logic [SW-1:0] stat = '0;
   logic          hv = 1'b0, ee = 1'b0, vx = 1'b0;
   logic          entry, clash;
   logic [4:0]    mode;
   logic [SW-1:0] snew, ssave;
   logic [AW-1:0] link, vec;
   int            total = 0;
   int            bad = 0;

   always #2 clk = ~clk;

   exc_entry_ctrl #(.ADDR_W(AW), .STAT_W(SW), .HI_BASE(32'hFFFF_0000), .EXT_VEC(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .req_rst_i(req[0]), .req_dabt_i(req[1]), .req_fiq_i(req[2]), .req_irq_i(req[3]),
      .req_iabt_i(req[4]), .req_pabt_i(req[5]), .req_und_i(req[6]), .req_swi_i(req[7]),
      .stat_i(stat), .pc_i(PC), .hivec_i(hv), .ee_i(ee), .vec_ext_en_i(vx), .vec_ext_i(VXT),
      .entry_o(entry), .mode_o(mode), .stat_new_o(snew), .stat_save_o(ssave),
      .link_o(link), .vec_o(vec), .clash_o(clash)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 entry in reset", 32'(entry), 0);
      chk("R11 vec in reset", vec, 0);
      chk("R11 link in reset", link, 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         req = TBL[i].req; stat = TBL[i].stat;
         hv = TBL[i].hv; ee = TBL[i].ee; vx = TBL[i].vx;
         @(negedge clk);
         chk($sformatf("R1 strobe v%0d", i), 32'(entry), 1);
         chk($sformatf("R7 R6 mode v%0d", i), 32'(mode), 32'(TBL[i].mode));
         chk($sformatf("R3 R4 R5 status v%0d", i), 32'(snew), 32'(TBL[i].snew));
         chk($sformatf("R8 saved v%0d", i), 32'(ssave), 32'(TBL[i].ssave));
         chk($sformatf("R2 R10 vector v%0d", i), vec, TBL[i].vec);
         chk($sformatf("R8 link v%0d", i), link, TBL[i].link);
         chk($sformatf("R9 clash v%0d", i), 32'(clash), 32'(TBL[i].clash));
         req = '0; vx = 1'b0;
         @(negedge clk);
      end

      // R5: masked interrupts alone produce no entry
      stat = 12'hC90; req = 8'h08;
      @(negedge clk);
      chk("R5 masked irq no entry", 32'(entry), 0);
      stat = 12'hC50; req = 8'h04;
      @(negedge clk);
      chk("R5 masked fiq no entry", 32'(entry), 0);
      req = '0; stat = 12'hC10;
      @(negedge clk);

      // R1: request changed during strobe waits one cycle
      req = 8'h80;
      @(negedge clk);
      chk("R1 first strobe", 32'(entry), 1);
      chk("R1 first mode", 32'(mode), 32'h13);
      req = 8'h08;
      @(negedge clk);
      chk("R1 blocked during strobe", 32'(entry), 0);
      chk("R1 outputs held", 32'(mode), 32'h13);
      @(negedge clk);
      chk("R1 pending taken next", 32'(entry), 1);
      chk("R1 pending mode", 32'(mode), 32'h12);
      req = '0;
      @(negedge clk);

      // R11: reset mid-run clears outputs
      req = 8'h40;
      @(negedge clk);
      chk("R11 pre-reset strobe", 32'(entry), 1);
      rst_n = 1'b0; req = '0;
      #1;
      chk("R11 entry cleared", 32'(entry), 0);
      chk("R11 link cleared", link, 0);
      chk("R11 status cleared", 32'(snew), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule